// File: doc/BRIEF.md
# Per-Port Cable PHY Status and Control Bank

This block keeps the status and control state of every port of a multi-port cable PHY and presents it to a link controller through a byte-wide register window. A port-select index picks one port. A small address picks the status byte or the control byte of that port, or a global byte that holds the port-event interrupt. The block registers the instantaneous line states of the port and filters its raw connection detect through a long debounce counter. It holds sticky fault flags, which software clears by writing 1. It drives the per-port disable and scrambler-off controls to the rest of the PHY, and it collects port events into one interrupt.

There are two reset inputs and they act differently. The asynchronous active-low hardware reset returns every field to its idle value. A bus reset is a synchronous pulse. It ends standby, so it clears only the standby-fault flag. Connection status, disable, interrupt enable, fault and scrambler control all pass through a bus reset unchanged.

Register layout. The status byte (address 0) holds, from bit 7 down: line A state [7:6], line B state [5:4], child [3], connected [2], receive-ok [1] and disable [0]. The control byte (address 1) holds: negotiated speed [7:5], interrupt enable [4], fault [3], standby fault [2], scrambler off [1], and a zero in bit 0. The global byte (address 2) holds the port-event interrupt in bit 0. Address 3 reads as zero.

Top module: `port_status_bank`

## Requirements
- R1: The status byte shows the 2-bit line A and line B states of the selected port in bits [7:6] and [5:4], unchanged from the inputs. The codes are 11 high-impedance, 01 one, 10 zero and 00 invalid.
- R2: The connected bit (status bit 2) becomes 1 on the DEBOUNCE_CYCLES-th consecutive clock edge at which the raw connect input is high, and not before.
- R3: Raw connect low at any edge resets the debounce count and clears the connected bit at that edge.
- R4: The child bit (status bit 3) reads 1 when the port is not connected, disabled or faulted. Otherwise it follows the arbiter child input.
- R5: The disable bit (status bit 0) is read/write and drives port_disabled. Bus reset leaves disable, connected, interrupt enable and fault unchanged.
- R6: A fault event sets the fault bit (control bit 3). The bit stays set until a 1 is written to it, and a set event wins over a clear in the same cycle.
- R7: A standby error sets the standby-fault bit (control bit 2). A 1 written to that bit, the standby-exit input, the clear-command input or a bus reset clears it.
- R8: A port event sets the sticky interrupt (global bit 0, port_irq) one edge later, but only if that port's interrupt enable (control bit 4) is 1. A port event is a change of the debounced connected bit, a change of receive-ok, or a fault event while the fault bit is clear. Writing 1 to global bit 0 clears the interrupt.
- R9: A port-select index at or above NUM_PORTS reads as zero from the status and control addresses, and writes to it change no port.
- R10: The scrambler-off bit (control bit 1) is read/write and drives scramble_off for its port.
- R11: Hardware reset clears disable, interrupt enable, fault, standby fault, scrambler off, connected, receive-ok and the interrupt.
- R12: The negotiated speed (control bits [7:5]) is read-only and shows the speed input of the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_reset | input | 1 | Synchronous bus reset pulse |
| reg_sel | input | PSEL_W | Port-select index |
| reg_addr | input | 2 | Register address: 0 status, 1 control, 2 global |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current select and address |
| line_a | input | 2*NUM_PORTS | Line A state per port |
| line_b | input | 2*NUM_PORTS | Line B state per port |
| conn_raw | input | NUM_PORTS | Raw connection detect per port |
| rx_ok | input | NUM_PORTS | Receive-ok per port |
| arb_child | input | NUM_PORTS | Child indication from the arbiter |
| neg_speed | input | 3*NUM_PORTS | Negotiated speed per port |
| fault_evt | input | NUM_PORTS | Resume or suspend fault event pulse |
| sby_err | input | NUM_PORTS | Standby error event pulse |
| sby_exit | input | NUM_PORTS | Standby exit pulse |
| sby_clr | input | NUM_PORTS | Clear-command pulse for standby fault |
| port_disabled | output | NUM_PORTS | Per-port disable control |
| scramble_off | output | NUM_PORTS | Per-port scrambler disable |
| port_irq | output | 1 | Sticky port-event interrupt |

## Verification
The assertions assume that the event inputs (fault, standby error, exit and clear command) are pulses sampled at clock edges, and that bus reset is a synchronous pulse that never lines up with a register write to the same field. The stimulus changes every input only on the falling clock edge. It holds each event high for exactly one rising edge, and it sends bus reset only in cycles without a write. Connection inputs stay stable long enough for each debounce boundary to be observed exactly.

// File: rtl/port_status_pkg.sv
package port_status_pkg;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_GLOBAL = 2'd2;

  // control-byte bit positions decoded by the slices
  localparam int CTRL_IE_BIT    = 4;
  localparam int CTRL_FAULT_BIT = 3;
  localparam int CTRL_SBY_BIT   = 2;
  localparam int CTRL_SCR_BIT   = 1;

  typedef struct packed {
    logic [1:0] line_a;
    logic [1:0] line_b;
    logic       child;
    logic       conn;
    logic       rx_ok;
    logic       dis;
  } status_byte_t;

  typedef struct packed {
    logic [2:0] speed;
    logic       irq_en;
    logic       fault;
    logic       sby_fault;
    logic       scr_off;
    logic       zero;
  } ctrl_byte_t;

endpackage

// File: rtl/psb_debounce.sv
module psb_debounce #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic conn_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          conn_q, conn_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = !raw_i || !conn_q;
    cnt_n  = cnt_q;
    conn_n = conn_q;
    if (!raw_i) begin
      cnt_n  = '0;
      conn_n = 1'b0;
    end else if (!conn_q) begin
      if (cnt_q == LAST) conn_n = 1'b1;
      else               cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      conn_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_n;
      conn_q <= conn_n;
    end
  end

  assign conn_o = conn_q;

  assert_conn_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_q |-> $past(raw_i));
  assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_i |=> !conn_q);

endmodule

// File: rtl/psb_port_slice.sv
module psb_port_slice
  import port_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset_i,
  input  logic       wr_status_i,
  input  logic       wr_ctrl_i,
  input  logic [4:0] wdata_i,
  input  logic       conn_i,
  input  logic       rx_ok_i,
  input  logic       fault_evt_i,
  input  logic       sby_err_i,
  input  logic       sby_exit_i,
  input  logic       sby_clr_i,
  output logic       dis_o,
  output logic       irq_en_o,
  output logic       fault_o,
  output logic       sby_o,
  output logic       scr_o,
  output logic       rx_ok_o,
  output logic       event_o
);
  logic dis_q, dis_n;
  logic ie_q, ie_n;
  logic scr_q, scr_n;
  logic fault_q, fault_n;
  logic sby_q, sby_n;
  logic rxq, rx_n;
  logic conn_seen_q;

  always_comb begin
    dis_n   = wr_status_i ? wdata_i[0] : dis_q;
    ie_n    = wr_ctrl_i ? wdata_i[CTRL_IE_BIT] : ie_q;
    scr_n   = wr_ctrl_i ? wdata_i[CTRL_SCR_BIT] : scr_q;
    fault_n = fault_evt_i | (fault_q & ~(wr_ctrl_i & wdata_i[CTRL_FAULT_BIT]));
    sby_n   = sby_err_i | (sby_q & ~(wr_ctrl_i & wdata_i[CTRL_SBY_BIT])
                                 & ~sby_exit_i & ~sby_clr_i & ~bus_reset_i);
    rx_n    = rx_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q       <= 1'b0;
      ie_q        <= 1'b0;
      scr_q       <= 1'b0;
      fault_q     <= 1'b0;
      sby_q       <= 1'b0;
      rxq         <= 1'b0;
      conn_seen_q <= 1'b0;
    end else begin
      if (wr_status_i) dis_q <= dis_n;
      if (wr_ctrl_i) begin
        ie_q  <= ie_n;
        scr_q <= scr_n;
      end
      fault_q     <= fault_n;
      sby_q       <= sby_n;
      rxq         <= rx_n;
      conn_seen_q <= conn_i;
    end
  end

  assign event_o  = ie_q & ((conn_i ^ conn_seen_q) | (rx_ok_i ^ rxq) | (fault_evt_i & ~fault_q));
  assign dis_o    = dis_q;
  assign irq_en_o = ie_q;
  assign fault_o  = fault_q;
  assign sby_o    = sby_q;
  assign scr_o    = scr_q;
  assign rx_ok_o  = rxq;

  assert_fault_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_i |=> fault_q);
  assert_sby_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sby_err_i |=> sby_q);
  assert_busrst_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !wr_status_i && !wr_ctrl_i && !fault_evt_i) |=>
      ($stable(dis_q) && $stable(ie_q) && $stable(fault_q)));
  assert_busrst_ends_sby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !sby_err_i) |=> !sby_q);

endmodule

// File: rtl/port_status_bank.sv
module port_status_bank
  import port_status_pkg::*;
#(
  parameter int NUM_PORTS       = 3,
  parameter int DEBOUNCE_CYCLES = 1000,
  parameter int PSEL_W          = $clog2(NUM_PORTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_reset,
  input  logic [PSEL_W-1:0]      reg_sel,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic [2*NUM_PORTS-1:0] line_a,
  input  logic [2*NUM_PORTS-1:0] line_b,
  input  logic [NUM_PORTS-1:0]   conn_raw,
  input  logic [NUM_PORTS-1:0]   rx_ok,
  input  logic [NUM_PORTS-1:0]   arb_child,
  input  logic [3*NUM_PORTS-1:0] neg_speed,
  input  logic [NUM_PORTS-1:0]   fault_evt,
  input  logic [NUM_PORTS-1:0]   sby_err,
  input  logic [NUM_PORTS-1:0]   sby_exit,
  input  logic [NUM_PORTS-1:0]   sby_clr,
  output logic [NUM_PORTS-1:0]   port_disabled,
  output logic [NUM_PORTS-1:0]   scramble_off,
  output logic                   port_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_PORTS-1:0] conn, wr_stat, wr_ctrl, ev;
  logic [NUM_PORTS-1:0] ie, fault, sby, rxq;
  status_byte_t stat_b [NUM_PORTS];
  ctrl_byte_t   ctrl_b [NUM_PORTS];
  logic         unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[7:5]};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign wr_stat[p] = reg_wr && (reg_sel == PSEL_W'(p)) && (reg_addr == ADDR_STATUS);
    assign wr_ctrl[p] = reg_wr && (reg_sel == PSEL_W'(p)) && (reg_addr == ADDR_CTRL);

    psb_debounce #(.LIMIT(DEBOUNCE_CYCLES)) i_deb (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .raw_i  (conn_raw[p]),
      .conn_o (conn[p])
    );

    psb_port_slice i_slice (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .bus_reset_i (bus_reset),
      .wr_status_i (wr_stat[p]),
      .wr_ctrl_i   (wr_ctrl[p]),
      .wdata_i     (reg_wdata[4:0]),
      .conn_i      (conn[p]),
      .rx_ok_i     (rx_ok[p]),
      .fault_evt_i (fault_evt[p]),
      .sby_err_i   (sby_err[p]),
      .sby_exit_i  (sby_exit[p]),
      .sby_clr_i   (sby_clr[p]),
      .dis_o       (port_disabled[p]),
      .irq_en_o    (ie[p]),
      .fault_o     (fault[p]),
      .sby_o       (sby[p]),
      .scr_o       (scramble_off[p]),
      .rx_ok_o     (rxq[p]),
      .event_o     (ev[p])
    );

    assign stat_b[p] = '{line_a: line_a[2*p +: 2],
                         line_b: line_b[2*p +: 2],
                         child:  arb_child[p] | ~conn[p] | port_disabled[p] | fault[p],
                         conn:   conn[p],
                         rx_ok:  rxq[p],
                         dis:    port_disabled[p]};
    assign ctrl_b[p] = '{speed:     neg_speed[3*p +: 3],
                         irq_en:    ie[p],
                         fault:     fault[p],
                         sby_fault: sby[p],
                         scr_off:   scramble_off[p],
                         zero:      1'b0};
  end

  // sticky port-event interrupt
  logic irq_q, irq_n, irq_en, wr_glob;

  always_comb begin
    wr_glob = reg_wr && (reg_addr == ADDR_GLOBAL);
    irq_en  = wr_glob || (|ev);
    irq_n   = (irq_q & ~(wr_glob & reg_wdata[0])) | (|ev);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  irq_q <= 1'b0;
    else if (irq_en)  irq_q <= irq_n;
  end
  assign port_irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_GLOBAL) begin
      reg_rdata = {7'b0, irq_q};
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reg_sel == PSEL_W'(p)) begin
          if (reg_addr == ADDR_STATUS)    reg_rdata = stat_b[p];
          else if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_b[p];
        end
      end
    end
  end

  assert_event_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ev) |=> port_irq);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (port_irq && !wr_glob) |=> port_irq);
  assert_oob_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((32'(reg_sel) >= NUM_PORTS) && (reg_addr != ADDR_GLOBAL)) |-> (reg_rdata == 8'h00));
  assert_oob_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && (32'(reg_sel) >= NUM_PORTS) && (reg_addr != ADDR_GLOBAL)) |=>
      ($stable(port_disabled) && $stable(scramble_off)));

endmodule

// File: tb/test_port_status_bank.sv
module test_port_status_bank;
  localparam int NP  = 3;
  localparam int DEB = 8;
  localparam int SW  = $clog2(NP + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bus_reset, reg_wr;
  logic [SW-1:0] reg_sel;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2*NP-1:0] line_a, line_b;
  logic [NP-1:0] conn_raw, rx_ok, arb_child, fault_evt, sby_err, sby_exit, sby_clr;
  logic [3*NP-1:0] neg_speed;
  logic [NP-1:0] port_disabled, scramble_off;
  logic port_irq;

  port_status_bank #(.NUM_PORTS(NP), .DEBOUNCE_CYCLES(DEB)) i_port_status_bank (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reg_sel(reg_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_a(line_a), .line_b(line_b), .conn_raw(conn_raw), .rx_ok(rx_ok),
    .arb_child(arb_child), .neg_speed(neg_speed), .fault_evt(fault_evt),
    .sby_err(sby_err), .sby_exit(sby_exit), .sby_clr(sby_clr),
    .port_disabled(port_disabled), .scramble_off(scramble_off), .port_irq(port_irq));

  typedef struct {
    logic [7:0] exp;
    int         kind;   // 0 rdata, 1 port_disabled, 2 scramble_off, 3 port_irq
    string      tag;
    int         due;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare once the expected item is due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = 8'(port_disabled);
        2: act = 8'(scramble_off);
        default: act = {7'b0, port_irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [1:0] addr, input logic [7:0] d);
    reg_sel = SW'(sel); reg_addr = addr; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: push expected item, wait for monitor to consume it
  task automatic chk(input int kind, input int sel, input logic [1:0] addr,
                     input logic [7:0] exp, input string tag);
    item_t it;
    reg_sel = SW'(sel); reg_addr = addr;
    it.exp = exp; it.kind = kind; it.tag = tag; it.due = cyc + 1;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_reset = 0; reg_wr = 0; reg_sel = '0; reg_addr = 0; reg_wdata = 0;
    line_a = {2'b11, 2'b10, 2'b01};
    line_b = {2'b00, 2'b00, 2'b11};
    conn_raw = 0; rx_ok = 0; arb_child = 0; fault_evt = 0;
    sby_err = 0; sby_exit = 0; sby_clr = 0;
    neg_speed = {3'b000, 3'b101, 3'b011};
    tick(3); rst_n = 1; tick(3);

    // reset state (R11) and line states (R1)
    chk(0, 0, 2'd0, 8'h78, "R11 reset status p0");
    chk(0, 0, 2'd1, 8'h60, "R11 reset ctrl p0 / R12 speed");
    chk(0, 0, 2'd2, 8'h00, "R11 reset global");
    chk(0, 1, 2'd0, 8'h88, "R1 lines p1 a=zero b=invalid");
    chk(0, 2, 2'd0, 8'hC8, "R1 lines p2 a=highZ");

    // debounce boundary (R2), child follows arbiter (R4)
    conn_raw[0] = 1'b1;
    tick(6);
    chk(0, 0, 2'd0, 8'h78, "R2 not connected before limit");
    chk(0, 0, 2'd0, 8'h74, "R2 connected at limit, R4 child=arb");

    // glitch restarts count, drop clears at once (R3)
    conn_raw[1] = 1'b1; tick(4);
    conn_raw[1] = 1'b0; tick(1);
    conn_raw[1] = 1'b1; tick(6);
    chk(0, 1, 2'd0, 8'h88, "R3 glitch restarted count");
    chk(0, 1, 2'd0, 8'h84, "R3 connected after full restart");
    conn_raw[1] = 1'b0;
    chk(0, 1, 2'd0, 8'h88, "R3 drop clears connected");

    // disable (R5) and child when disabled (R4)
    wr(0, 2'd0, 8'h01);
    chk(0, 0, 2'd0, 8'h7D, "R4 disabled port reads child");
    chk(1, 0, 2'd0, 8'h01, "R5 port_disabled output");

    // fault sticky, W1C (R6)
    conn_raw[1] = 1'b1; tick(9);
    fault_evt[1] = 1'b1; tick(1); fault_evt[1] = 1'b0;
    chk(0, 1, 2'd0, 8'h8C, "R4 faulted port reads child");
    chk(0, 1, 2'd1, 8'hA8, "R6 fault sticky");
    wr(1, 2'd1, 8'h08);
    chk(0, 1, 2'd1, 8'hA0, "R6 fault W1C");
    chk(0, 1, 2'd0, 8'h84, "R6 child back after clear");

    // bus reset effects (R5, R7, R10)
    wr(2, 2'd1, 8'h12);
    sby_err[2] = 1'b1; tick(1); sby_err[2] = 1'b0;
    chk(0, 2, 2'd1, 8'h16, "R7 standby fault set");
    fault_evt[1] = 1'b1; tick(1); fault_evt[1] = 1'b0;
    bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
    chk(0, 0, 2'd0, 8'h7D, "R5 bus reset keeps disable and connected");
    chk(0, 1, 2'd1, 8'hA8, "R5 bus reset keeps fault");
    chk(0, 2, 2'd1, 8'h12, "R7 bus reset clears standby, R5 keeps ie");
    chk(2, 0, 2'd0, 8'h04, "R10 scramble_off output");

    // standby clear paths (R7)
    sby_err[2] = 1'b1; tick(1); sby_err[2] = 1'b0;
    wr(2, 2'd1, 8'h16);
    chk(0, 2, 2'd1, 8'h12, "R7 standby W1C");
    sby_err[2] = 1'b1; tick(1); sby_err[2] = 1'b0;
    sby_exit[2] = 1'b1; tick(1); sby_exit[2] = 1'b0;
    chk(0, 2, 2'd1, 8'h12, "R7 standby exit clears");
    sby_err[2] = 1'b1; tick(1); sby_err[2] = 1'b0;
    sby_clr[2] = 1'b1; tick(1); sby_clr[2] = 1'b0;
    chk(0, 2, 2'd1, 8'h12, "R7 clear command clears");

    // interrupt (R8)
    chk(3, 0, 2'd2, 8'h00, "R8 no event no irq");
    rx_ok[2] = 1'b1;
    chk(3, 0, 2'd2, 8'h01, "R8 rx change raises irq");
    chk(0, 0, 2'd2, 8'h01, "R8 global read");
    wr(0, 2'd2, 8'h01);
    chk(3, 0, 2'd2, 8'h00, "R8 irq W1C");
    rx_ok[1] = 1'b1; tick(2);
    fault_evt[0] = 1'b1; tick(1); fault_evt[0] = 1'b0;
    chk(3, 0, 2'd2, 8'h00, "R8 masked ports ignored");
    conn_raw[2] = 1'b1; tick(9);
    chk(3, 0, 2'd2, 8'h01, "R8 connect change raises irq");
    chk(0, 2, 2'd0, 8'hC6, "R4 connected child from arbiter p2");

    // out-of-range select (R9), read-only speed (R12)
    chk(0, 3, 2'd0, 8'h00, "R9 oob status zero");
    chk(0, 3, 2'd1, 8'h00, "R9 oob ctrl zero");
    wr(3, 2'd0, 8'hFF);
    wr(3, 2'd1, 8'hFF);
    chk(1, 0, 2'd0, 8'h01, "R9 oob write leaves disables");
    chk(2, 0, 2'd0, 8'h04, "R9 oob write leaves scrambler");
    wr(1, 2'd1, 8'h00);
    chk(0, 1, 2'd1, 8'hA8, "R12 speed read-only");

    // hardware reset (R11)
    conn_raw = 0; rx_ok = 0;
    tick(1); rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
    chk(0, 0, 2'd0, 8'h78, "R11 hw reset status p0");
    chk(0, 1, 2'd1, 8'hA0, "R11 hw reset clears fault");
    chk(0, 2, 2'd1, 8'h00, "R11 hw reset clears ctrl p2");
    chk(3, 0, 2'd2, 8'h00, "R11 hw reset clears irq");
    chk(1, 0, 2'd0, 8'h00, "R11 hw reset enables ports");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule